// File: doc/BRIEF.md
# Power-Down Wake-Up Counter

This block is a free-running wake-up timer meant to keep ticking while the rest of the system is powered down. It is a 23-bit down counter. The low 7 bits act as a prescaler and the high 16 bits as a reloadable counter. Each time the whole value reaches zero, it reloads from a programmed value and raises a sticky flag. That flag drives an interrupt request and a wake-up request, and each request has its own enable.

The counter runs from one of two clocks: the CPU clock or the crystal oscillator. When the crystal is already serving as the CPU clock, the block uses the CPU clock no matter what the select says. Only the active-low power-on reset clears the block; it has no other reset.

Top module: `pd_wake_counter`

## Requirements
- R1: While por_n is low, count is 0, flag is 0, and irq_req and wake_req are 0. The reset acts asynchronously.
- R2: On the first counting-clock edge at which enable is high after being low, count loads {reload, 7'h7F}. reload forms bits 22:7 and the prescaler forms bits 6:0.
- R3: While enable stays high and count is nonzero, count drops by one per counting-clock edge. Bits 22:7 therefore drop once each time bits 6:0 wrap from 0 to 127.
- R4: On an edge with enable held high and count equal to 0, count reloads {reload, 7'h7F} and flag goes to 1. One period therefore lasts (reload+1)*128 edges.
- R5: A change of reload while counting has no effect on count until the next zero reload or enable rise.
- R6: flag stays 1 until an edge with flag_clr high, which clears it. A zero reload on the same edge wins and keeps flag at 1.
- R7: irq_req equals flag AND irq_en, and wake_req equals flag AND wake_en. Both are combinational.
- R8: While enable is low, count holds its value.
- R9: The counter is clocked by clk_xtal when use_xtal is 1 and xtal_is_cpu is 0. Otherwise it is clocked by clk_cpu.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU clock |
| clk_xtal | input | 1 | Crystal oscillator clock |
| use_xtal | input | 1 | Select the crystal as the counting clock |
| xtal_is_cpu | input | 1 | Crystal is currently the CPU clock, which forces clk_cpu |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| enable | input | 1 | Run the counter; a rising level loads the reload value |
| reload | input | 16 | Reload value for the upper 16 bits |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en | input | 1 | Interrupt request enable |
| wake_en | input | 1 | Wake-up request enable |
| flag | output | 1 | Sticky zero-reached flag |
| irq_req | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-up request |
| count | output | 23 | Current counter value {upper 16, prescaler 7} |

## Verification
Count and flag sit one register behind their inputs. A load or a zero reload therefore appears right after the counting-clock edge that saw it, and the bench drives inputs on the falling edge and samples on the next falling edge after exactly N rising edges. The zero reload is checked at (reload+1)*128 edges after the load, with flag sampled one edge before and at that point. The request outputs are combinational and are sampled 1 ns after their inputs change. For the crystal clock, the bench counts its own crystal rising edges and samples 3 ns after one, so each expected decrement equals the number of edges it counted.

// File: rtl/pd_wake_counter.sv
module pd_wake_counter #(
  parameter int PRE_W = 7,
  parameter int CNT_W = 16
) (
  input  logic                   clk_cpu,
  input  logic                   clk_xtal,
  input  logic                   use_xtal,
  input  logic                   xtal_is_cpu,
  input  logic                   por_n,
  input  logic                   enable,
  input  logic [CNT_W-1:0]       reload,
  input  logic                   flag_clr,
  input  logic                   irq_en,
  input  logic                   wake_en,
  output logic                   flag,
  output logic                   irq_req,
  output logic                   wake_req,
  output logic [CNT_W+PRE_W-1:0] count
);
  localparam int W = CNT_W + PRE_W;

  logic rclk;
  logic en_q;
  logic run, at_zero, wrap;
  logic [W-1:0] load_val;

  assign rclk     = (use_xtal && !xtal_is_cpu) ? clk_xtal : clk_cpu;
  assign run      = enable && en_q;
  assign at_zero  = (count == '0);
  assign wrap     = run && at_zero;
  assign load_val = {reload, {PRE_W{1'b1}}};

  always_ff @(posedge rclk or negedge por_n) begin
    if (!por_n) begin
      en_q  <= 1'b0;
      count <= '0;
      flag  <= 1'b0;
    end else begin
      en_q <= enable;
      if (enable && !en_q) count <= load_val;
      else if (wrap)       count <= load_val;
      else if (run)        count <= count - 1'b1;
      if (wrap)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  assign irq_req  = flag && irq_en;
  assign wake_req = flag && wake_en;

  AST_DECREMENT: assert property (@(posedge rclk) disable iff (!por_n)
    (run && !at_zero) |=> (count == $past(count) - 1'b1)); // R3
  AST_ZERO_SETS_FLAG: assert property (@(posedge rclk) disable iff (!por_n)
    wrap |=> (flag && count == {$past(reload), {PRE_W{1'b1}}})); // R4
  AST_HOLD_IDLE: assert property (@(posedge rclk) disable iff (!por_n)
    !enable |=> $stable(count)); // R8
  AST_FLAG_STICKY: assert property (@(posedge rclk) disable iff (!por_n)
    (flag && !flag_clr) |=> flag); // R6
  AST_FLAG_CLEAR: assert property (@(posedge rclk) disable iff (!por_n)
    (flag_clr && !wrap) |=> !flag); // R6
  AST_REQ_GATED: assert property (@(posedge rclk) disable iff (!por_n)
    (irq_req || wake_req) |-> flag); // R7
endmodule

// File: tb/test_pd_wake_counter.sv
module test_pd_wake_counter;
  logic clk_cpu = 1'b0, clk_xtal = 1'b0;
  logic use_xtal = 1'b0, xtal_is_cpu = 1'b0, por_n = 1'b0, enable = 1'b0;
  logic [15:0] reload = '0;
  logic flag_clr = 1'b0, irq_en = 1'b0, wake_en = 1'b0;
  logic flag, irq_req, wake_req;
  logic [22:0] count;
  int checks = 0, fails = 0;
  logic [22:0] c0;

  always #2 clk_cpu = ~clk_cpu;
  always #10 clk_xtal = ~clk_xtal;

  pd_wake_counter i_pd_wake_counter (
    .clk_cpu(clk_cpu), .clk_xtal(clk_xtal), .use_xtal(use_xtal),
    .xtal_is_cpu(xtal_is_cpu), .por_n(por_n), .enable(enable), .reload(reload),
    .flag_clr(flag_clr), .irq_en(irq_en), .wake_en(wake_en), .flag(flag),
    .irq_req(irq_req), .wake_req(wake_req), .count(count));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_cpu);
    @(negedge clk_cpu);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 count", count, 0); chk("R1 flag", flag, 0);
    chk("R1 irq", irq_req, 0); chk("R1 wake", wake_req, 0);
    @(negedge clk_cpu); por_n = 1'b1; step(1);
  endtask

  task automatic t_load_and_count;
    reload = 16'd3; enable = 1'b1; step(1);
    chk("R2 load", count, 511);
    step(5); chk("R3 decrement", count, 506);
    step(123); chk("R3 prescaler wrap", count, 383);
  endtask

  task automatic t_zero;
    enable = 1'b0; step(1);
    reload = 16'd1; enable = 1'b1; step(1);
    chk("R2 reload", count, 255);
    step(255); chk("R4 at zero", count, 0); chk("R4 flag before", flag, 0);
    step(1); chk("R4 reload", count, 255); chk("R4 flag set", flag, 1);
  endtask

  task automatic t_clear_and_late_reload;
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R6 clear", flag, 0); chk("R3 count", count, 254);
    reload = 16'd5; step(1); chk("R5 no effect", count, 253);
    step(253); step(1);
    chk("R5 new reload", count, 767); chk("R4 flag", flag, 1);
    step(10); chk("R6 sticky", flag, 1);
  endtask

  task automatic t_requests;
    irq_en = 1'b0; wake_en = 1'b0; #1;
    chk("R7 irq off", irq_req, 0); chk("R7 wake off", wake_req, 0);
    @(negedge clk_cpu); irq_en = 1'b1; #1;
    chk("R7 irq on", irq_req, 1); chk("R7 wake gated", wake_req, 0);
    @(negedge clk_cpu); irq_en = 1'b0; wake_en = 1'b1; #1;
    chk("R7 wake on", wake_req, 1); chk("R7 irq gated", irq_req, 0);
    @(negedge clk_cpu); irq_en = 1'b1; flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R7 irq after clear", irq_req, 0); chk("R7 wake after clear", wake_req, 0);
  endtask

  task automatic t_hold;
    enable = 1'b0; step(1); c0 = count;
    step(20); chk("R8 hold", count, c0);
    reload = 16'd7; enable = 1'b1; step(1); chk("R2 rise reload", count, 1023);
  endtask

  task automatic t_clock_select;
    enable = 1'b0; use_xtal = 1'b1; xtal_is_cpu = 1'b0; step(2);
    @(negedge clk_xtal); reload = 16'd100; enable = 1'b1;
    @(posedge clk_xtal); #3;
    chk("R9 xtal load", count, 12927);
    c0 = count;
    repeat (40) @(posedge clk_xtal);
    #3; chk("R9 xtal pace", c0 - count, 40);
    @(negedge clk_xtal); enable = 1'b0;
    @(posedge clk_xtal); #3; xtal_is_cpu = 1'b1;
    @(negedge clk_cpu); enable = 1'b1; step(1);
    chk("R9 forced cpu load", count, 12927);
    c0 = count; step(50); chk("R9 forced cpu pace", c0 - count, 50);
  endtask

  task automatic t_por;
    flag_clr = 1'b0; step(3);
    por_n = 1'b0; #1;
    chk("R1 por count", count, 0); chk("R1 por flag", flag, 0);
    @(negedge clk_cpu); por_n = 1'b1;
  endtask

  task automatic t_por_flag;
    use_xtal = 1'b0; xtal_is_cpu = 1'b0; enable = 1'b0; step(1);
    reload = 16'd0; enable = 1'b1; step(1); step(128);
    chk("R4 short period flag", flag, 1);
    @(negedge clk_cpu); por_n = 1'b0; #1;
    chk("R1 por clears flag", flag, 0); chk("R1 por clears irq", irq_req, 0);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset;
    t_load_and_count;
    t_zero;
    t_clear_and_late_reload;
    t_requests;
    t_hold;
    t_clock_select;
    t_por;
    t_por_flag;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule